// File: doc/BRIEF.md
# Serial Lane Reset Sequencer

This block controls when the reset of each part of one serial lane is released. A board-level reset is the only input that resets the block itself. After that reset is released, the block frees the transceiver SERDES and tells the application logic that it can leave reset. The transmit digital path stays in reset until the transmit PLL has reported lock for an unbroken run of clock cycles.

The receive side goes through a small link-bring-up state machine. The link waits in a quiet phase until the receive PLL locks. It then waits in a detect phase until the PHY reports that a receiver is present, which it signals as a one-cycle strobe together with status code 3. It then enters a polling phase. In the polling phase the receive digital path leaves reset only after signal detect has been present without a break for a programmable number of cycles. The default for that count is 3 ms at the configured clock rate, so simulation can use a much shorter window.

All timing is counted in core clock cycles. The reset input is active-low and is sampled on the clock.

Top module: `lane_reset_sequencer`

## Requirements
- R1: On every clock edge that samples `rst_n` low, the block returns to its reset state after that edge: `serdes_hold`, `tx_core_hold`, `rx_core_hold` and `app_hold` are all 1, and `link_phase` is 0 (quiet).
- R2: `serdes_hold` and `app_hold` fall to 0 at the first clock edge that samples `rst_n` high.
- R3: `tx_core_hold` falls to 0 at the edge where `tx_lock_in` has been sampled high, with `serdes_hold` low, on TX_LOCK_CYCLES (default 127) consecutive edges. It returns to 1 at the first edge that samples `tx_lock_in` low.
- R4: `link_phase` encodes quiet as 0, detect as 1 and polling as 2. In quiet, an edge that samples `rx_lock_in` high moves the phase to detect.
- R5: From detect, the phase moves to polling only on an edge that samples `det_strobe` high while `det_code` equals 3. A strobe with any other code, or code 3 without the strobe, leaves the phase in detect.
- R6: `rx_core_hold` is 1 in every phase except polling. In polling it falls to 0 at the edge where `sig_present` has been sampled high on SIG_CYCLES consecutive edges since the phase was entered.
- R7: A single low sample of `tx_lock_in` or `sig_present` while its run is being counted discards the run, and the full count starts again from zero.
- R8: An edge that samples `rx_lock_in` low while the phase is detect or polling returns the phase to 0, and `rx_core_hold` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all windows are counted on this clock |
| rst_n | input | 1 | Board/power-on reset, active low, sampled on the clock |
| tx_lock_in | input | 1 | Transmit PLL lock indication |
| rx_lock_in | input | 1 | Receive PLL lock indication |
| det_strobe | input | 1 | One-cycle PHY status strobe |
| det_code | input | 3 | PHY receiver status; 3 means receiver detected |
| sig_present | input | 1 | Receive signal-detect flag |
| serdes_hold | output | 1 | SERDES reset, active high |
| tx_core_hold | output | 1 | Transmit digital reset, active high |
| rx_core_hold | output | 1 | Receive digital reset, active high |
| app_hold | output | 1 | Application reset status, high while in reset |
| link_phase | output | 2 | Link bring-up phase: 0 quiet, 1 detect, 2 polling |

## Verification
The embedded assertions check, on every cycle, the local cause of each change. A released transmit reset implies lock at the previous edge. Entry into detect or polling implies that the qualifying input was present at that edge. A released receive reset implies the polling phase and signal detect at the previous edge. A loss of receive lock forces the quiet phase. The assertions cannot see how long a window lasted, so the exact 127-cycle and SIG_CYCLES thresholds, the restart after a one-cycle dropout, and the rejection of every non-3 status code are shown only by the bench. The bench sweeps each window edge by edge and steps through all eight status codes.

// File: rtl/lane_reset_pkg.sv
// Shared types for the lane reset sequencer.
// Assumes: the phase encoding is visible at the top-level port and is fixed.
package lane_reset_pkg;

    typedef enum logic [1:0] {
        PH_QUIET  = 2'd0,
        PH_DETECT = 2'd1,
        PH_POLL   = 2'd2
    } link_phase_t;

    localparam logic [2:0] RCV_FOUND_CODE = 3'd3;

endpackage

// File: rtl/hold_timer.sv
// Stability window counter. It counts consecutive clock edges on which
// `level` is high and raises `done` once LIMIT such edges have been seen.
// Any low sample, or reset, clears the run. The count saturates at LIMIT.
// Assumes: LIMIT >= 1; synchronous active-low reset.
module hold_timer #(
    parameter int unsigned LIMIT = 127
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] run_q;

    // Count the unbroken run of high samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !level) begin
            run_q <= '0;
        end else if (run_q != TOP) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Window complete once the run reaches the limit.
    assign done = (run_q == TOP);

    // R7: the run counter never passes its limit, so a restart is always from a bounded value
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= TOP);

endmodule

// File: rtl/link_phase_fsm.sv
// Simplified link bring-up phases: quiet -> detect on receive PLL lock,
// detect -> polling on a receiver-found PHY strobe. Lock loss drops to quiet.
// Assumes: det_strobe is qualified by det_code in the same cycle.
module link_phase_fsm
    import lane_reset_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_lock_in,
    input  logic        det_strobe,
    input  logic [2:0]  det_code,
    output link_phase_t phase
);
    link_phase_t phase_q, phase_d;
    logic        found;

    // A receiver is found only when the strobe and code 3 coincide.
    assign found = det_strobe && (det_code == RCV_FOUND_CODE);

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_QUIET:  if (rx_lock_in) phase_d = PH_DETECT;
            PH_DETECT: if (!rx_lock_in) phase_d = PH_QUIET;
                       else if (found) phase_d = PH_POLL;
            PH_POLL:   if (!rx_lock_in) phase_d = PH_QUIET;
            default:   phase_d = PH_QUIET;
        endcase
    end

    // Phase register with synchronous reset to quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_QUIET;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R4: leaving quiet for detect needs receive lock at that edge
    assert_quiet_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DETECT && $past(phase_q) == PH_QUIET) |-> $past(rx_lock_in));

    // R5: polling is entered only on a strobe carrying code 3
    assert_poll_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_POLL && $past(phase_q) != PH_POLL) |->
            ($past(det_strobe) && $past(det_code) == 3'd3));

    // R8: losing receive lock forces the quiet phase
    assert_lock_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_lock_in |=> phase_q == PH_QUIET);

endmodule

// File: rtl/lane_reset_sequencer.sv
// Top of the lane reset sequencer. It releases the SERDES and the application
// status after board reset, releases transmit digital reset after a PLL lock
// window, and releases receive digital reset after the bring-up FSM reaches
// polling and signal detect has been stable for SIG_CYCLES.
// Assumes: all inputs are synchronous to clk; synchronous active-low reset.
module lane_reset_sequencer
    import lane_reset_pkg::*;
#(
    parameter int unsigned TX_LOCK_CYCLES = 127,
    parameter int unsigned CLK_KHZ        = 100000,
    parameter int unsigned SIG_CYCLES     = CLK_KHZ * 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_lock_in,
    input  logic       rx_lock_in,
    input  logic       det_strobe,
    input  logic [2:0] det_code,
    input  logic       sig_present,
    output logic       serdes_hold,
    output logic       tx_core_hold,
    output logic       rx_core_hold,
    output logic       app_hold,
    output logic [1:0] link_phase
);
    logic        serdes_q;
    logic        app_q;
    logic        tx_done;
    logic        rx_done;
    logic        tx_run;
    logic        rx_run;
    link_phase_t phase;

    // SERDES reset follows the board reset, released one edge after it.
    always_ff @(posedge clk) begin
        if (!rst_n) serdes_q <= 1'b1;
        else        serdes_q <= 1'b0;
    end

    // Application reset status, released on the same edge as the SERDES.
    always_ff @(posedge clk) begin
        if (!rst_n) app_q <= 1'b1;
        else        app_q <= 1'b0;
    end

    // Transmit lock window counts only once the SERDES is out of reset.
    assign tx_run = tx_lock_in && !serdes_q;

    hold_timer #(.LIMIT(TX_LOCK_CYCLES)) u_tx_window (
        .clk   (clk),
        .rst_n (rst_n),
        .level (tx_run),
        .done  (tx_done)
    );

    link_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_lock_in (rx_lock_in),
        .det_strobe (det_strobe),
        .det_code   (det_code),
        .phase      (phase)
    );

    // Signal-detect window runs only in polling with lock still held.
    assign rx_run = sig_present && rx_lock_in && (phase == PH_POLL);

    hold_timer #(.LIMIT(SIG_CYCLES)) u_rx_window (
        .clk   (clk),
        .rst_n (rst_n),
        .level (rx_run),
        .done  (rx_done)
    );

    assign serdes_hold  = serdes_q;
    assign app_hold     = app_q;
    assign tx_core_hold = !tx_done;
    assign rx_core_hold = !(rx_done && (phase == PH_POLL));
    assign link_phase   = phase;

    // R2: once reset was high at the previous edge, SERDES and application are free
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (!serdes_hold && !app_hold));

    // R3: transmit reset is released only if lock was present at the last edge
    assert_tx_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_core_hold |-> $past(tx_lock_in));

    // R6: receive reset is released only in polling with signal detect at the last edge
    assert_rx_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_core_hold |-> (link_phase == 2'd2 && $past(sig_present)));

endmodule

// File: tb/sim_lane_reset_sequencer.sv
module sim_lane_reset_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int TXW = 127;
    localparam int SIGW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_lock_in = 1'b0;
    logic rx_lock_in = 1'b0;
    logic det_strobe = 1'b0;
    logic [2:0] det_code = 3'd0;
    logic sig_present = 1'b0;
    logic serdes_hold, tx_core_hold, rx_core_hold, app_hold;
    logic [1:0] link_phase;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lane_reset_sequencer #(.TX_LOCK_CYCLES(TXW), .SIG_CYCLES(SIGW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_lock_in(tx_lock_in), .rx_lock_in(rx_lock_in),
        .det_strobe(det_strobe), .det_code(det_code), .sig_present(sig_present),
        .serdes_hold(serdes_hold), .tx_core_hold(tx_core_hold),
        .rx_core_hold(rx_core_hold), .app_hold(app_hold), .link_phase(link_phase)
    );

    // One posedge, then back to the falling edge where sampling and driving happen.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_reset_state(input string req);
        check(req, serdes_hold, 1);
        check(req, tx_core_hold, 1);
        check(req, rx_core_hold, 1);
        check(req, app_hold, 1);
        check(req, link_phase, 0);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc();
        cyc();
        check_reset_state("R1 power-on");

        // R2: release on the first edge sampling rst_n high
        rst_n = 1'b1;
        cyc();
        check("R2 serdes", serdes_hold, 0);
        check("R2 app", app_hold, 0);
        check("R3 tx before lock", tx_core_hold, 1);
        check("R6 rx in quiet", rx_core_hold, 1);
        cyc();
        cyc();

        // R3: full transmit window sweep
        tx_lock_in = 1'b1;
        for (int n = 1; n <= TXW + 3; n++) begin
            cyc();
            check("R3 tx window", tx_core_hold, (n < TXW) ? 1 : 0);
        end
        tx_lock_in = 1'b0;
        cyc();
        check("R3 tx relock loss", tx_core_hold, 1);

        // R7: partial run, one-cycle dropout, then full count again
        tx_lock_in = 1'b1;
        for (int n = 1; n <= 100; n++) cyc();
        check("R7 tx partial", tx_core_hold, 1);
        tx_lock_in = 1'b0;
        cyc();
        tx_lock_in = 1'b1;
        for (int n = 1; n <= TXW + 3; n++) begin
            cyc();
            check("R7 tx restart", tx_core_hold, (n < TXW) ? 1 : 0);
        end

        // R4: quiet holds without lock, then moves to detect
        for (int n = 0; n < 3; n++) begin
            cyc();
            check("R4 quiet holds", link_phase, 0);
        end
        rx_lock_in = 1'b1;
        cyc();
        check("R4 to detect", link_phase, 1);
        check("R6 rx in detect", rx_core_hold, 1);

        // R5: every code other than 3 with the strobe is ignored
        sig_present = 1'b1;
        for (int c = 0; c < 8; c++) begin
            if (c != 3) begin
                det_strobe = 1'b1;
                det_code = 3'(c);
                cyc();
                det_strobe = 1'b0;
                check("R5 wrong code", link_phase, 1);
            end
        end
        det_code = 3'd3;
        cyc();
        check("R5 code without strobe", link_phase, 1);
        check("R6 rx still held", rx_core_hold, 1);
        det_strobe = 1'b1;
        cyc();
        det_strobe = 1'b0;
        det_code = 3'd0;
        check("R5 to polling", link_phase, 2);
        check("R6 polling entry", rx_core_hold, 1);

        // R6: signal-detect window sweep
        for (int n = 1; n <= SIGW + 3; n++) begin
            cyc();
            check("R6 rx window", rx_core_hold, (n < SIGW) ? 1 : 0);
        end

        // R7: dropout of signal detect restarts the window
        sig_present = 1'b0;
        cyc();
        check("R7 rx dropout", rx_core_hold, 1);
        sig_present = 1'b1;
        for (int n = 1; n <= SIGW + 3; n++) begin
            cyc();
            check("R7 rx restart", rx_core_hold, (n < SIGW) ? 1 : 0);
        end

        // R8: receive lock loss from polling
        rx_lock_in = 1'b0;
        cyc();
        check("R8 phase quiet", link_phase, 0);
        check("R8 rx held", rx_core_hold, 1);

        // R8: lock loss from detect
        rx_lock_in = 1'b1;
        cyc();
        check("R8 back to detect", link_phase, 1);
        rx_lock_in = 1'b0;
        cyc();
        check("R8 detect to quiet", link_phase, 0);

        // R1: reset in mid-operation
        rx_lock_in = 1'b1;
        cyc();
        rst_n = 1'b0;
        cyc();
        check_reset_state("R1 mid-run");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule